// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programmable state of a 24-input interrupt router: one 64-bit routing entry per input line, a 4-bit controller identifier, an arbitration word and a fixed version word. Software does not address these registers directly. It first writes a register index into a small select port, then reads or writes the chosen register through a 32-bit data window. A 64-bit routing entry is reached as two 32-bit halves, and the lowest bit of the index picks which half.

The block claims a bus access only when it is enabled and the address lies inside its window in the address map. The window starts at a programmable base, which resets to 0xFEC00000 with the block enabled. Inside the window only the low address byte is decoded. The full routing table is driven out as one flat vector, so the servicing and delivery logic can read every entry's vector, trigger mode, mask and destination at any time. A read of an index that names no register returns zero and sets a sticky error flag.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, every routing entry holds 0x0000000000010000 (only the mask bit, bit 16, set). The controller ID is 0, the error flag is 0, the base is 0xFEC00000 and the block is enabled.
- R2: `addr_hit` is 1 exactly when the block is enabled and base <= address <= base + 0x100, with both ends included. An access with `addr_hit` low changes no register.
- R3: Only address bits 7:0 are decoded. Low byte 0x00 is the select port and low byte 0x10 is the data window. The select port holds an 8-bit index and reads back the last value written to it. Reads at any other low byte return 0, and writes there are ignored.
- R4: Window index 0x01 reads (PINS-1) in bits 23:16 and the version code 0x11 in bits 7:0, which gives 0x00170011 at 24 pins. Writes to index 0x01 are ignored.
- R5: A write to index 0x00 stores data bits 27:24 as the controller ID. Reads of index 0x00 and of index 0x02 both return the ID in bits 27:24 with all other bits zero. A write to index 0x02 stores the full word in the arbitration register (`arb_value`) and leaves the ID unchanged.
- R6: Index 0x10 + 2*n + h reaches entry n for n < PINS. h = 1 selects bits 63:32 and h = 0 selects bits 31:0. A write to one half leaves the other half unchanged.
- R7: `route_table[64*n +: 64]` equals entry n. Its fields are vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16] and destination ID [63:56].
- R8: A window read of an index that names no register (0x03 to 0x0F, or 0x10 + 2*PINS and above) returns 0 and sets `bad_index_err`. The flag stays set until reset. A window write to such an index changes no register and does not set the flag.
- R9: `rd_valid` pulses high for the single cycle that follows a claimed read, and `rd_data` carries the result during that cycle. Writes never raise `rd_valid`.
- R10: A cycle with `cfg_load` high loads the base from `cfg_base` and the enable from `cfg_enable`. The new values decide `addr_hit` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load base address and enable |
| cfg_base | input | 32 | New window base address |
| cfg_enable | input | 1 | New enable value |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Write data |
| addr_hit | output | 1 | Address lies in the enabled window (combinational) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| bad_index_err | output | 1 | Sticky flag: an undefined index was read |
| arb_value | output | 32 | Arbitration register contents |
| route_table | output | PINS*64 | All routing entries, entry n at bits 64n+63:64n |

## Verification
`addr_hit` is combinational, so the bench samples it at the falling edge in the same cycle it applies the address. Register writes take effect at the next rising edge, and their effects on `route_table`, `arb_value` and later reads are checked one falling edge later. A read result is due exactly one cycle after the strobe. The driver queues the expected word when it applies the strobe, and a monitor takes it from the queue at the falling edge where `rd_valid` is high. A result that comes early, comes late or is missing therefore shows up as a mismatch or as a queue left non-empty. The error flag is checked one cycle after the offending read, and again after a bad-index write.

// File: rtl/irq_route_pkg.sv
// Package: shared constants and index kinds for the routing register file.
// Assumes a 32-bit data word and an 8-bit register index.
package irq_route_pkg;
    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int IDX_W   = 8;

    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] IDX_TBL0 = 8'h10;

    localparam int MASK_BIT = 16;
    localparam logic [7:0] VER_CODE = 8'h11;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENTRY,
        K_NONE
    } idx_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
// Module: address-window and register-index decoder.
// Produces the window hit, the port selected by the low address byte, and
// the register kind, entry number and half that the select index names.
// Assumes PINS <= 120, so every entry is reachable with an 8-bit index.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int PINS   = 24,
    parameter int ADDR_W = 32,
    parameter int SPAN   = 256,
    localparam int ENT_W = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              enable,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic              hit,
    output logic              at_select,
    output logic              at_window,
    output idx_kind_e         kind,
    output logic [ENT_W-1:0]  ent_num,
    output logic              upper
);
    localparam logic [6:0]    PINS_L = 7'(PINS);
    localparam logic [ADDR_W:0] SPAN_L = (ADDR_W+1)'(SPAN);

    logic [ADDR_W:0] lim;
    logic [7:0]      rel;
    logic [6:0]      ent_raw;

    // Inclusive range test against base .. base+SPAN, without wrap-around.
    always_comb begin
        lim = {1'b0, base} + SPAN_L;
        hit = enable && (addr >= base) && ({1'b0, addr} <= lim);
    end

    // Low-byte port decode.
    always_comb begin
        at_select = (addr[7:0] == OFS_SELECT);
        at_window = (addr[7:0] == OFS_WINDOW);
    end

    // Index decode into register kind, entry number and half.
    always_comb begin
        rel     = sel_idx - IDX_TBL0;
        ent_raw = rel[7:1];
        ent_num = ent_raw[ENT_W-1:0];
        upper   = sel_idx[0];
        if (sel_idx == IDX_ID)                                kind = K_ID;
        else if (sel_idx == IDX_VER)                          kind = K_VER;
        else if (sel_idx == IDX_ARB)                          kind = K_ARB;
        else if ((sel_idx >= IDX_TBL0) && (ent_raw < PINS_L)) kind = K_ENTRY;
        else                                                  kind = K_NONE;
    end
endmodule

// File: rtl/irq_route_table.sv
// Module: routing-entry storage.
// One 64-bit register per input line, written one 32-bit half at a time.
// On reset each entry holds only its mask bit. Read is combinational.
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int PINS = 24,
    localparam int ENT_W = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ENT_W-1:0]      wr_ent,
    input  logic                  wr_upper,
    input  logic [WORD_W-1:0]     wr_word,
    input  logic [ENT_W-1:0]      rd_ent,
    output logic [ENTRY_W-1:0]    rd_entry,
    output logic [PINS*ENTRY_W-1:0] flat
);
    localparam logic [ENTRY_W-1:0] ENT_RST = ENTRY_W'(1) << MASK_BIT;

    logic [ENTRY_W-1:0] ent_q [PINS];

    for (genvar e = 0; e < PINS; e++) begin : g_ent
        // Hold entry e; replace only the addressed half on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[e] <= ENT_RST;
            end else if (wr_en && (wr_ent == ENT_W'(e))) begin
                if (wr_upper) ent_q[e][63:32] <= wr_word;
                else          ent_q[e][31:0]  <= wr_word;
            end
        end
        assign flat[e*ENTRY_W +: ENTRY_W] = ent_q[e];
    end

    // Read mux for the window path.
    always_comb begin
        rd_entry = ent_q[rd_ent];
    end
endmodule

// File: rtl/irq_route_regfile.sv
// Module: top of the indirect-access routing register file.
// Holds the select index, controller ID, arbitration word, window base and
// enable, and the read/error state. Acts on an access only when it is
// claimed (strobe and window hit). The read result is registered and so
// appears one cycle after the strobe.
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int          PINS     = 24,
    parameter int          ADDR_W   = 32,
    parameter int          SPAN     = 256,
    parameter logic [31:0] BASE_RST = 32'hFEC0_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic                    cfg_enable,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [WORD_W-1:0]       acc_wdata,
    output logic                    addr_hit,
    output logic                    rd_valid,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    bad_index_err,
    output logic [WORD_W-1:0]       arb_value,
    output logic [PINS*ENTRY_W-1:0] route_table
);
    localparam int ENT_W = (PINS > 1) ? $clog2(PINS) : 1;
    localparam logic [7:0] LAST_PIN = 8'(PINS - 1);

    logic [IDX_W-1:0]  sel_q;
    logic [3:0]        id_q;
    logic [WORD_W-1:0] arb_q;
    logic [ADDR_W-1:0] base_q;
    logic              en_q;
    logic              rdv_q;
    logic [WORD_W-1:0] rdd_q;
    logic              err_q;

    logic              at_select, at_window, upper;
    idx_kind_e         kind;
    logic [ENT_W-1:0]  ent_num;
    logic [ENTRY_W-1:0] cur_entry;
    logic              claim_rd, claim_wr, tbl_wr;
    logic [WORD_W-1:0] rd_mux;

    irq_route_decode #(.PINS(PINS), .ADDR_W(ADDR_W), .SPAN(SPAN)) u_dec (
        .addr      (acc_addr),
        .base      (base_q),
        .enable    (en_q),
        .sel_idx   (sel_q),
        .hit       (addr_hit),
        .at_select (at_select),
        .at_window (at_window),
        .kind      (kind),
        .ent_num   (ent_num),
        .upper     (upper)
    );

    // Qualify the strobe with the window hit.
    always_comb begin
        claim_rd = acc_valid && addr_hit && !acc_write;
        claim_wr = acc_valid && addr_hit && acc_write;
        tbl_wr   = claim_wr && at_window && (kind == K_ENTRY);
    end

    irq_route_table #(.PINS(PINS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_ent   (ent_num),
        .wr_upper (upper),
        .wr_word  (acc_wdata),
        .rd_ent   (ent_num),
        .rd_entry (cur_entry),
        .flat     (route_table)
    );

    // Select the word returned for a read at the current address and index.
    always_comb begin
        rd_mux = '0;
        if (at_select) begin
            rd_mux = {{(WORD_W-IDX_W){1'b0}}, sel_q};
        end else if (at_window) begin
            case (kind)
                K_ID, K_ARB: rd_mux = {4'b0, id_q, 24'b0};
                K_VER:       rd_mux = {8'b0, LAST_PIN, 8'b0, VER_CODE};
                K_ENTRY:     rd_mux = upper ? cur_entry[63:32] : cur_entry[31:0];
                default:     rd_mux = '0;
            endcase
        end
    end

    // Select, ID and arbitration registers updated by claimed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
        end else if (claim_wr) begin
            if (at_select) begin
                sel_q <= acc_wdata[IDX_W-1:0];
            end else if (at_window) begin
                if (kind == K_ID)  id_q  <= acc_wdata[27:24];
                if (kind == K_ARB) arb_q <= acc_wdata;
            end
        end
    end

    // Window base and enable, reloaded by the configuration strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= ADDR_W'(BASE_RST);
            en_q   <= 1'b1;
        end else if (cfg_load) begin
            base_q <= cfg_base;
            en_q   <= cfg_enable;
        end
    end

    // Registered read result and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q <= 1'b0;
            rdd_q <= '0;
        end else begin
            rdv_q <= claim_rd;
            if (claim_rd) rdd_q <= rd_mux;
        end
    end

    // Sticky flag for reads of an undefined index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (claim_rd && at_window && (kind == K_NONE))
            err_q <= 1'b1;
    end

    assign rd_valid      = rdv_q;
    assign rd_data       = rdd_q;
    assign bad_index_err = err_q;
    assign arb_value     = arb_q;
endmodule

// File: rtl/irq_route_checker.sv
// Module: protocol checker for the routing register file, bound to the top.
// Assumes only the top's ports; all properties are disabled during reset.
module irq_route_checker #(
    parameter int PINS = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               addr_hit,
    input logic               rd_valid,
    input logic [31:0]        rd_data,
    input logic               bad_index_err,
    input logic [PINS*64-1:0] route_table
);
    AST_UNCLAIMED_NO_TABLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && addr_hit) |=> $stable(route_table)); // R2

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && addr_hit && !acc_write) |=> rd_valid); // R9

    AST_VALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && addr_hit && !acc_write)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_index_err |=> bad_index_err); // R8

    AST_ERR_RISE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_index_err) |-> (rd_valid && (rd_data == 32'h0))); // R8
endmodule

bind irq_route_regfile irq_route_checker #(.PINS(PINS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .addr_hit      (addr_hit),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .bad_index_err (bad_index_err),
    .route_table   (route_table)
);

// File: tb/sim_irq_route_regfile.sv
// Bench: scoreboard for the routing register file. Read tasks queue the
// expected word; a monitor compares it when rd_valid appears.
module sim_irq_route_regfile;
    localparam int          CLK_NS = 10;
    localparam int          PINS   = 24;
    localparam logic [31:0] BASE   = 32'hFEC0_0000;
    localparam logic [31:0] SELA   = BASE;
    localparam logic [31:0] WINA   = BASE + 32'h10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_load = 1'b0;
    logic [31:0]        cfg_base = '0;
    logic               cfg_enable = 1'b0;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic [31:0]        acc_addr = '0;
    logic [31:0]        acc_wdata = '0;
    logic               addr_hit;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic               bad_index_err;
    logic [31:0]        arb_value;
    logic [PINS*64-1:0] route_table;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    irq_route_regfile #(.PINS(PINS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_enable(cfg_enable), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .addr_hit(addr_hit),
        .rd_valid(rd_valid), .rd_data(rd_data), .bad_index_err(bad_index_err),
        .arb_value(arb_value), .route_table(route_table)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare at each falling edge with a valid result.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected rd_valid", 64'(rd_valid), 64'h0);
            end else begin
                chk(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        chk("R9 no rd_valid after write", 64'(rd_valid), 64'h0);
    endtask

    task automatic rd(logic [31:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wwin(logic [7:0] idx, logic [31:0] d);
        wr(SELA, 32'(idx));
        wr(WINA, d);
    endtask

    task automatic rwin(logic [7:0] idx, logic [31:0] e, string tag);
        wr(SELA, 32'(idx));
        rd(WINA, e, tag);
    endtask

    task automatic hit_at(logic [31:0] a, logic e, string tag);
        @(negedge clk);
        acc_addr = a;
        #1 chk(tag, 64'(addr_hit), 64'(e));
    endtask

    task automatic cfg(logic [31:0] b, logic en);
        @(negedge clk);
        cfg_load = 1'b1; cfg_base = b; cfg_enable = en;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 err after reset", 64'(bad_index_err), 64'h0);
        chk("R9 no rd_valid after reset", 64'(rd_valid), 64'h0);
        chk("R1 entry0 reset", route_table[0 +: 64], 64'h0000_0000_0001_0000);
        chk("R1 entry23 reset", route_table[23*64 +: 64], 64'h0000_0000_0001_0000);
        rwin(8'h1A, 32'h0001_0000, "R1 entry5 low reset");
        rwin(8'h1B, 32'h0, "R1 entry5 high reset");
        rwin(8'h00, 32'h0, "R1 id reset");
        // R2 window bounds at reset base
        hit_at(BASE, 1'b1, "R2 hit at base");
        hit_at(BASE + 32'h100, 1'b1, "R2 hit at base+0x100");
        hit_at(BASE + 32'h101, 1'b0, "R2 miss above");
        hit_at(BASE - 32'h1, 1'b0, "R2 miss below");
        // R4 version word, write ignored
        rwin(8'h01, 32'h0017_0011, "R4 version");
        wwin(8'h01, 32'hFFFF_FFFF);
        rwin(8'h01, 32'h0017_0011, "R4 version after write");
        // R5 ID and arbitration
        wwin(8'h00, 32'hA500_0000);
        rwin(8'h00, 32'h0500_0000, "R5 id read");
        rwin(8'h02, 32'h0500_0000, "R5 arb index reads id");
        wwin(8'h02, 32'h0F00_1234);
        rwin(8'h00, 32'h0500_0000, "R5 id kept after arb write");
        chk("R5 arb value", 64'(arb_value), 64'h0F00_1234);
        // R3 select readback, low-byte decode, other offsets
        wr(SELA, 32'h0000_003A);
        rd(SELA, 32'h0000_003A, "R3 select readback");
        wr(BASE + 32'h100, 32'h0000_0021);
        rd(SELA, 32'h0000_0021, "R3 low byte only decoded");
        rd(BASE + 32'h20, 32'h0, "R3 other offset reads zero");
        wr(BASE + 32'h20, 32'h0000_0055);
        rd(SELA, 32'h0000_0021, "R3 other offset write ignored");
        // R6 halves and preservation
        wwin(8'h16, 32'h0000_C0F1);
        wwin(8'h17, 32'hAB00_0000);
        rwin(8'h16, 32'h0000_C0F1, "R6 entry3 low");
        rwin(8'h17, 32'hAB00_0000, "R6 entry3 high");
        wwin(8'h16, 32'h0000_0012);
        rwin(8'h17, 32'hAB00_0000, "R6 high kept after low write");
        wwin(8'h3F, 32'h7700_0000);
        rwin(8'h3F, 32'h7700_0000, "R6 last entry high");
        rwin(8'h3E, 32'h0001_0000, "R6 last entry low kept");
        // R7 table output fields
        chk("R7 entry3 flat", route_table[3*64 +: 64], 64'hAB00_0000_0000_0012);
        chk("R7 vector field", 64'(route_table[3*64 +: 8]), 64'h12);
        chk("R7 mask field", 64'(route_table[3*64 + 16]), 64'h0);
        chk("R7 dest field", 64'(route_table[3*64 + 56 +: 8]), 64'hAB);
        wwin(8'h1E, 32'h0001_8040);
        chk("R7 trigger field", 64'(route_table[7*64 + 15]), 64'h1);
        chk("R7 entry23 dest", 64'(route_table[23*64 + 56 +: 8]), 64'h77);
        // R8 undefined indices
        wwin(8'h41, 32'hDEAD_BEEF);
        wwin(8'h05, 32'hDEAD_BEEF);
        chk("R8 bad write leaves flag", 64'(bad_index_err), 64'h0);
        rwin(8'h10, 32'h0001_0000, "R8 entry0 low unchanged");
        rwin(8'h11, 32'h0, "R8 entry0 high unchanged");
        rwin(8'h40, 32'h0, "R8 bad read zero");
        @(negedge clk);
        chk("R8 flag set", 64'(bad_index_err), 64'h1);
        rwin(8'h01, 32'h0017_0011, "R8 good read after error");
        chk("R8 flag sticky", 64'(bad_index_err), 64'h1);
        // R10 configuration reload, R2 unclaimed ignored
        cfg(32'h0000_1000, 1'b1);
        hit_at(32'h0000_1010, 1'b1, "R10 hit at new base");
        hit_at(BASE, 1'b0, "R10 old base missed");
        wr(32'h0000_1000, 32'h0000_0002);
        rd(32'h0000_1000, 32'h0000_0002, "R10 select at new base");
        cfg(32'h0000_1000, 1'b0);
        hit_at(32'h0000_1010, 1'b0, "R10 disabled no hit");
        wr(32'h0000_1000, 32'h0000_0055);
        wr(32'h0000_1010, 32'h0000_0099);
        cfg(32'h0000_1000, 1'b1);
        rd(32'h0000_1000, 32'h0000_0002, "R2 unclaimed write ignored");
        rd(32'h0000_1010, 32'h0500_0000, "R2 arb index still reads id");
        chk("R2 arb unchanged", 64'(arb_value), 64'h0F00_1234);
        repeat (3) @(negedge clk);
        chk("R9 all reads answered", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule